// File: doc/BRIEF.md
# Multi-Lane Comma Deskew Buffer

This block lines up several receive lanes that carry already-decoded 8B/10B bytes. All lanes run from one clock at exactly the same rate, but each lane reaches the block with its own fixed delay. Each lane delivers one byte per clock, together with a control-character flag and a comma-detect flag. Every lane has a small FIFO. The block uses the comma flags as markers: it drops leading bytes until each lane has a comma at its FIFO head, then pops all lanes together. After that point, bytes that were sent in the same cycle leave the block in the same cycle.

There is no rate matching. With zero frequency offset between lanes, FIFO occupancy stays constant once the lanes are locked, so no character is ever added or removed. If one lane's comma does not arrive in time, the block reports a skew error and starts the search again. A bypass input sends the lane inputs to the outputs with no delay and holds the aligner idle.

Top module: `comma_deskew`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `aligned` and `skew_err` are 0, and with `bypass` low `out_data`, `out_k` and `out_comma` are all zero.
- R2: Lockstep reading starts only when every lane has a comma at its FIFO head. In the first cycle `aligned` is 1, every bit of `out_comma` is 1.
- R3: While `aligned` is 1, all lanes present the same source cycle in each output cycle. Lane i uses `out_data[i*8 +: 8]`, `out_k[i]` and `out_comma[i]`. Bytes sent in the same cycle on all lanes therefore come out equal on all lanes.
- R4: When the difference between the largest and smallest lane delay is at most 24 byte times, the block reaches `aligned` = 1 and does not raise `skew_err`.
- R5: When that difference is 25 byte times or more, the block raises `skew_err` and never reaches `aligned` = 1. The error fires when at least one lane holds a comma and some other lane has not shown one for 24 cycles. The search then restarts with empty FIFOs.
- R6: If the comma flags disagree among the lanes in an output cycle while aligned, `aligned` drops to 0. The lanes that hold a comma keep it, and alignment is reached again without a skew error when the new skew is within limits.
- R7: While `bypass` is 1, the outputs equal the lane inputs in the same cycle. From the second cycle of bypass onwards, `aligned` is 0.
- R8: `skew_err` is a single-cycle pulse. It is never high in two consecutive cycles, and it is never high together with `aligned`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock shared by all lanes |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | 1 = pass the lane inputs straight through and hold the aligner idle |
| lane_data | input | LANES*DW | Decoded byte for each lane; lane i at bits [i*DW +: DW] |
| lane_k | input | LANES | Control-character flag for each lane |
| lane_comma | input | LANES | Comma-detect flag for each lane |
| out_data | output | LANES*DW | Aligned byte for each lane (the input bytes when bypassed) |
| out_k | output | LANES | Aligned control-character flag for each lane |
| out_comma | output | LANES | Aligned comma flag for each lane |
| aligned | output | 1 | 1 while the lanes are read in lockstep |
| skew_err | output | 1 | One-cycle pulse when the lane skew exceeds the limit |

## Verification
A table of per-lane delay sets covers three cases: no skew, spreads up to exactly 24 with the late lane in different positions, and spreads of 25. These cases separate acceptance from timeout at the boundary, and they show that alignment does not depend on which lane comes last. Further delay sets drawn at random in 0 to 24 check that outputs from the same source cycle match across lanes for a long run. A mid-run delay step on one lane shows that loss of alignment is detected and recovered without a false skew error. A bypass phase separates the pass-through path from the FIFO path.

// File: rtl/comma_deskew_pkg.sv
package comma_deskew_pkg;
   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_LOCK = 1'b1
   } dsk_state_e;
endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [DW+1:0] wr_word,
   input  logic          pop,
   output logic [DW+1:0] head_word,
   output logic          head_vld
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int WW = DW + 2;

   logic [WW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [PW:0]   cnt;
   logic          do_wr, do_rd;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign do_wr = !flush && (cnt != (PW+1)'(DEPTH));
   assign do_rd = !flush && pop && (cnt != '0);

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= nxt(wp);
         if (do_rd) rp <= nxt(rp);
         cnt <= cnt + (PW+1)'(do_wr) - (PW+1)'(do_rd);
      end
   end

   assign head_word = mem[rp];
   assign head_vld  = (cnt != '0);
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
   import comma_deskew_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int SKEW_LIMIT = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bypass,
   input  logic [LANES-1:0] head_vld,
   input  logic [LANES-1:0] head_comma,
   output logic [LANES-1:0] pop,
   output logic             flush,
   output logic             load_out,
   output logic             aligned,
   output logic             skew_err
);
   localparam int CW = $clog2(SKEW_LIMIT + 1);

   dsk_state_e state;
   logic [CW-1:0] wait_cnt;
   logic all_c, any_c, locked, mism, partial, timeout, take;

   always_comb begin
      all_c    = &(head_vld & head_comma);
      any_c    = |(head_vld & head_comma);
      locked   = (state == ST_LOCK);
      mism     = locked && any_c && !all_c;
      partial  = !locked && any_c && !all_c;
      timeout  = !bypass && partial && (wait_cnt == CW'(SKEW_LIMIT));
      take     = locked ? !mism : all_c;
      pop      = bypass ? '0 : (take ? '1 : (head_vld & ~head_comma));
      load_out = !bypass && take;
      flush    = bypass || timeout;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_HUNT;
         wait_cnt <= '0;
         skew_err <= 1'b0;
      end else begin
         state    <= (!bypass && !timeout && take) ? ST_LOCK : ST_HUNT;
         wait_cnt <= (!bypass && partial && !timeout) ? wait_cnt + 1'b1 : '0;
         skew_err <= timeout;
      end
   end

   assign aligned = (state == ST_LOCK);
endmodule

// File: rtl/comma_deskew.sv
module comma_deskew #(
   parameter int LANES      = 4,
   parameter int DW         = 8,
   parameter int SKEW_LIMIT = 24,
   parameter int DEPTH      = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bypass,
   input  logic [LANES*DW-1:0] lane_data,
   input  logic [LANES-1:0]    lane_k,
   input  logic [LANES-1:0]    lane_comma,
   output logic [LANES*DW-1:0] out_data,
   output logic [LANES-1:0]    out_k,
   output logic [LANES-1:0]    out_comma,
   output logic                aligned,
   output logic                skew_err
);
   localparam int WW = DW + 2;

   if (LANES < 2) begin : g_bad_lanes
      $error("comma_deskew: LANES must be at least 2");
   end
   if (DEPTH < SKEW_LIMIT + 2) begin : g_bad_depth
      $error("comma_deskew: DEPTH must exceed SKEW_LIMIT + 1");
   end

   logic [LANES-1:0]    head_vld, head_comma, pop;
   logic                flush, load_out;
   logic [LANES*DW-1:0] q_data;
   logic [LANES-1:0]    q_k, q_comma;
   logic [WW-1:0]       head_w [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      deskew_lane_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush),
         .wr_word   ({lane_comma[g], lane_k[g], lane_data[g*DW +: DW]}),
         .pop       (pop[g]),
         .head_word (head_w[g]),
         .head_vld  (head_vld[g])
      );
      assign head_comma[g] = head_w[g][WW-1];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_data[g*DW +: DW] <= '0;
            q_k[g]             <= 1'b0;
            q_comma[g]         <= 1'b0;
         end else if (load_out) begin
            q_data[g*DW +: DW] <= head_w[g][DW-1:0];
            q_k[g]             <= head_w[g][DW];
            q_comma[g]         <= head_w[g][WW-1];
         end
      end
   end

   deskew_ctrl #(.LANES(LANES), .SKEW_LIMIT(SKEW_LIMIT)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bypass     (bypass),
      .head_vld   (head_vld),
      .head_comma (head_comma),
      .pop        (pop),
      .flush      (flush),
      .load_out   (load_out),
      .aligned    (aligned),
      .skew_err   (skew_err)
   );

   assign out_data  = bypass ? lane_data  : q_data;
   assign out_k     = bypass ? lane_k     : q_k;
   assign out_comma = bypass ? lane_comma : q_comma;
endmodule

// File: rtl/comma_deskew_chk.sv
module comma_deskew_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bypass,
   input logic [LANES-1:0] out_comma,
   input logic             aligned,
   input logic             skew_err
);
   // R2
   lock_on_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aligned) |-> (&out_comma));

   // R3
   lockstep_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && !bypass) |-> ((out_comma == '0) || (&out_comma)));

   // R7
   bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && $past(bypass)) |-> !aligned);

   // R8
   skew_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skew_err |=> !skew_err);

   // R8
   skew_not_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skew_err |-> !aligned);
endmodule

bind comma_deskew comma_deskew_chk #(.LANES(LANES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bypass    (bypass),
   .out_comma (out_comma),
   .aligned   (aligned),
   .skew_err  (skew_err)
);

// File: tb/comma_deskew_tb_top.sv
module comma_deskew_tb_top;
   localparam int LANES = 4;
   localparam int DW    = 8;
   localparam int NVEC  = 7;
   // {expect_ok, d3, d2, d1, d0}
   localparam logic [20:0] VEC [NVEC] = '{
      {1'b1, 5'd0,  5'd0,  5'd0,  5'd0},
      {1'b1, 5'd24, 5'd10, 5'd5,  5'd0},
      {1'b1, 5'd3,  5'd12, 5'd0,  5'd24},
      {1'b1, 5'd0,  5'd12, 5'd12, 5'd12},
      {1'b0, 5'd9,  5'd4,  5'd25, 5'd0},
      {1'b0, 5'd5,  5'd5,  5'd5,  5'd30},
      {1'b1, 5'd17, 5'd1,  5'd25, 5'd25}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bypass = 1'b0;
   logic [LANES*DW-1:0] lane_data = '0;
   logic [LANES-1:0]    lane_k = '0, lane_comma = '0;
   logic [LANES*DW-1:0] out_data;
   logic [LANES-1:0]    out_k, out_comma;
   logic aligned, skew_err;

   int checks = 0, fails = 0, m = 0;
   int dly [LANES];

   always #2 clk = ~clk;

   comma_deskew dut_i (
      .clk(clk), .rst_n(rst_n), .bypass(bypass),
      .lane_data(lane_data), .lane_k(lane_k), .lane_comma(lane_comma),
      .out_data(out_data), .out_k(out_k), .out_comma(out_comma),
      .aligned(aligned), .skew_err(skew_err)
   );

   function automatic logic [9:0] src(input int idx);
      if (idx < 0) return 10'h000;
      if (idx % 64 == 0) return {2'b11, 8'hBC};
      return {2'b00, 8'(idx) ^ 8'h5A};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive();
      for (int i = 0; i < LANES; i++) begin
         logic [9:0] w;
         w = src(m - dly[i]);
         lane_comma[i]         = w[9];
         lane_k[i]             = w[8];
         lane_data[i*DW +: DW] = w[7:0];
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      drive();
      m++;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n  = 1'b0;
      bypass = 1'b0;
      m = 0;
      lane_data = '0; lane_k = '0; lane_comma = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic lineup(input string req, input int n);
      bit bad = 0;
      int act = 0, exp = 0;
      for (int t = 0; t < n; t++) begin
         cyc();
         for (int i = 1; i < LANES; i++) begin
            if (!bad && (out_data[i*DW +: DW] != out_data[7:0] ||
                         out_k[i] != out_k[0] || out_comma[i] != out_comma[0] ||
                         !aligned)) begin
               bad = 1;
               act = int'(out_data[i*DW +: DW]);
               exp = int'(out_data[7:0]);
            end
         end
      end
      check(!bad, req, "lanes line up while aligned", act, exp);
   endtask

   task automatic run_case(input bit ok);
      bit sk = 0, dbl = 0, al = 0;
      do_reset();
      if (ok) begin
         for (int t = 0; t < 200 && !aligned; t++) begin
            cyc();
            if (skew_err) sk = 1;
         end
         check(aligned == 1'b1, "R4", "aligned reached", int'(aligned), 1);
         check(!sk, "R4", "no skew error within limit", int'(sk), 0);
         check(&out_comma, "R2", "first aligned word is comma", int'(out_comma), 15);
         lineup("R3", 100);
      end else begin
         logic prev = 1'b0;
         for (int t = 0; t < 250; t++) begin
            cyc();
            if (skew_err) sk = 1;
            if (skew_err && prev) dbl = 1;
            if (aligned) al = 1;
            prev = skew_err;
         end
         check(sk, "R5", "skew error raised", int'(sk), 1);
         check(!al, "R5", "never aligned beyond limit", int'(al), 0);
         check(!dbl, "R8", "skew error single pulse", int'(dbl), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < LANES; i++) dly[i] = 0;
      // R1: reset state
      @(posedge clk); #1;
      check(aligned == 1'b0, "R1", "aligned in reset", int'(aligned), 0);
      check(skew_err == 1'b0, "R1", "skew_err in reset", int'(skew_err), 0);
      check(out_data == '0 && out_k == '0 && out_comma == '0, "R1",
            "outputs in reset", int'(out_data[7:0]), 0);
      do_reset();
      @(posedge clk); #1;
      check(aligned == 1'b0 && skew_err == 1'b0, "R1", "status after reset",
            int'(aligned), 0);

      // table of delay sets
      for (int v = 0; v < NVEC; v++) begin
         for (int i = 0; i < LANES; i++) dly[i] = int'(VEC[v][i*5 +: 5]);
         run_case(VEC[v][20]);
      end

      // random delays within 0..24
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < LANES; i++) dly[i] = int'($urandom_range(24, 0));
         run_case(1'b1);
      end

      // R6: one lane steps by two bytes while locked
      for (int i = 0; i < LANES; i++) dly[i] = 3;
      run_case(1'b1);
      dly[2] = 5;
      begin
         bit sk = 0, dropped = 0;
         for (int t = 0; t < 80 && !dropped; t++) begin
            cyc();
            if (!aligned) dropped = 1;
         end
         check(dropped, "R6", "aligned drops on comma mismatch", int'(dropped), 1);
         for (int t = 0; t < 80 && !aligned; t++) begin
            cyc();
            if (skew_err) sk = 1;
         end
         check(aligned == 1'b1, "R6", "realigned after mismatch", int'(aligned), 1);
         check(!sk, "R6", "no skew error on realign", int'(sk), 0);
         lineup("R6", 70);
      end

      // R7: bypass
      begin
         bit bad = 0, al = 0;
         @(negedge clk);
         bypass = 1'b1;
         for (int t = 0; t < 12; t++) begin
            cyc();
            if (out_data != lane_data || out_k != lane_k || out_comma != lane_comma)
               bad = 1;
            if (t > 0 && aligned) al = 1;
         end
         check(!bad, "R7", "bypass passes inputs", int'(bad), 0);
         check(!al, "R7", "aligned low in bypass", int'(al), 0);
         @(negedge clk);
         bypass = 1'b0;
         for (int t = 0; t < 200 && !aligned; t++) cyc();
         check(aligned == 1'b1, "R7", "realign after bypass", int'(aligned), 1);
         lineup("R3", 50);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule